// File: doc/BRIEF.md
# Sequential Unsigned Divider with Byte and Word Sizes

This block performs unsigned integer division over several clock cycles. It works on operands that are packed the way an accumulator pair holds them. A size select picks one of two forms. In byte form, the whole 16-bit `axIn` value is divided by the low 8 bits of `divisor`. In word form, a 32-bit dividend is built from `dxIn` as the upper word and `axIn` as the lower word, and it is divided by all 16 bits of `divisor`. The results come back in the same packing:

- Byte form: the quotient lands in the low byte of `axOut` and the remainder in its high byte.
- Word form: the quotient replaces `axOut` and the remainder replaces `dxOut`.

The operation starts with a one-cycle `start` strobe. The unit captures every operand in that cycle and ignores `start` until it is free again. It produces one quotient bit per clock using restoring shift-and-subtract, so a byte operation takes 8 cycles and a word operation takes 16.

A division is refused when the divisor is zero or when the quotient would not fit its destination. In that case the fault flag rises together with the completion pulse, and the outputs hold exactly the operand values that were presented.

Top module: `divUnit`

## Requirements
- R1: In byte mode (`wordMode`=0), the dividend is `axIn[15:0]` and the divisor is `divisor[7:0]`; `divisor[15:8]` has no effect on the result.
- R2: In byte mode, a successful result places the quotient in `axOut[7:0]` and the remainder in `axOut[15:8]`.
- R3: In word mode (`wordMode`=1), the dividend is {`dxIn`,`axIn`} and the divisor is `divisor[15:0]`; the quotient appears on `axOut` and the remainder on `dxOut`.
- R4: In byte mode, `dxOut` equals the `dxIn` value captured with `start`.
- R5: A zero divisor makes `fault` assert with `done`, and `axOut`/`dxOut` equal the captured `axIn`/`dxIn`.
- R6: A quotient above 255 (byte mode) or above 65535 (word mode) also asserts `fault` with `done` and leaves the outputs equal to the captured inputs.
- R7: `done` rises after the 8th rising edge following the accepting edge in byte mode and after the 16th in word mode; a faulting operation shows `done` right after the accepting edge.
- R8: `done` is high for exactly one cycle per operation, and `fault` is never high without `done`.
- R9: A `start` pulse while an operation is in progress is ignored; the running operation finishes with its original operands and timing.
- R10: A `start` presented during the cycle in which `done` is high is accepted, so operations can run back to back.
- R11: After reset, `done`, `fault`, `axOut` and `dxOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| wordMode | input | 1 | 0 = byte divide, 1 = word divide |
| divisor | input | 16 | Divisor; only the low 8 bits are used in byte mode |
| axIn | input | 16 | Low dividend word (whole dividend in byte mode) |
| dxIn | input | 16 | High dividend word in word mode; passed through in byte mode |
| axOut | output | 16 | New low register value |
| dxOut | output | 16 | New high register value |
| done | output | 1 | One-cycle pulse when the result or fault is valid |
| fault | output | 1 | Division refused (zero divisor or quotient overflow), valid with done |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle, because `done` marks an idle controller that will take a `start` on the following edge. The bench provokes this by raising `start` with fresh operands on the same sample in which it sees `done`. It then judges that the second result arrives with the full latency counted from that edge and carries the new operands' values. A variant of this test chains a faulting request directly after a good one and checks that `done` appears on two adjacent cycles, with `fault` set only on the second.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes sent from the controller to the datapath each cycle
  typedef struct packed {
    logic load;    // capture operands and output registers
    logic step;    // perform one shift-subtract iteration
    logic commit;  // last iteration: write results to outputs
  } divStrobeT;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      wordMode,
  input  logic      tooBig,
  output divStrobeT strb,
  output logic      done,
  output logic      fault
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             doneQ;
  logic             faultQ;
  logic             accept;
  logic             lastStep;

  assign accept   = start && !busy;
  assign lastStep = busy && (cnt == CNT_W'(1));

  always_comb begin
    strb.load   = accept;
    strb.step   = busy;
    strb.commit = lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
      if (accept) begin
        if (tooBig) begin
          doneQ  <= 1'b1;
          faultQ <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= wordMode ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
        end
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (lastStep) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign done  = doneQ;
  assign fault = faultQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> (!doneQ || faultQ)); // R8

  AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> doneQ); // R8

  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> (busy && cnt == CNT_W'($past(cnt) - 1'b1))); // R9

  AST_LATENCY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !tooBig) |=> (cnt == (($past(wordMode)) ? CNT_W'(DATA_W) : CNT_W'(HALF_W)))); // R7

endmodule

// File: rtl/divPath.sv
module divPath
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobeT         strb,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] divisor,
  input  logic [DATA_W-1:0] axIn,
  input  logic [DATA_W-1:0] dxIn,
  output logic              tooBig,
  output logic [DATA_W-1:0] axOut,
  output logic [DATA_W-1:0] dxOut
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] remQ;
  logic [DATA_W-1:0] quoQ;
  logic [DATA_W-1:0] divQ;
  logic              modeQ;
  logic [DATA_W-1:0] axQ;
  logic [DATA_W-1:0] dxQ;

  logic [DATA_W:0]   shifted;
  logic [DATA_W:0]   diff;
  logic              take;
  logic [DATA_W-1:0] nextRem;
  logic [DATA_W-1:0] nextQuo;
  logic [DATA_W-1:0] byteHigh;
  logic [DATA_W-1:0] byteDiv;

  // Zero-extended byte-mode views of the operands
  assign byteHigh = {{HALF_W{1'b0}}, axIn[DATA_W-1:HALF_W]};
  assign byteDiv  = {{HALF_W{1'b0}}, divisor[HALF_W-1:0]};

  // The quotient fits only if the upper dividend half is below the divisor
  assign tooBig = wordMode ? (dxIn >= divisor) : (byteHigh >= byteDiv);

  // One restoring iteration
  always_comb begin
    shifted = {remQ, quoQ[DATA_W-1]};
    diff    = shifted - {1'b0, divQ};
    take    = (shifted >= {1'b0, divQ});
    nextRem = take ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
    nextQuo = {quoQ[DATA_W-2:0], take};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ  <= '0;
      quoQ  <= '0;
      divQ  <= '0;
      modeQ <= 1'b0;
      axQ   <= '0;
      dxQ   <= '0;
    end else if (strb.load) begin
      remQ  <= wordMode ? dxIn : byteHigh;
      quoQ  <= wordMode ? axIn : {axIn[HALF_W-1:0], {HALF_W{1'b0}}};
      divQ  <= wordMode ? divisor : byteDiv;
      modeQ <= wordMode;
      axQ   <= axIn;
      dxQ   <= dxIn;
    end else if (strb.step) begin
      remQ <= nextRem;
      quoQ <= nextQuo;
      if (strb.commit) begin
        if (modeQ) begin
          axQ <= nextQuo;
          dxQ <= nextRem;
        end else begin
          axQ <= {nextRem[HALF_W-1:0], nextQuo[HALF_W-1:0]};
        end
      end
    end
  end

  assign axOut = axQ;
  assign dxOut = dxQ;

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (remQ < divQ)); // R3

  AST_FAULT_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && tooBig) |=> (axOut == $past(axIn) && dxOut == $past(dxIn))); // R5

  AST_BYTE_DX_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !modeQ) |=> $stable(dxOut)); // R4

  AST_NO_ZERO_DIV_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (divQ != '0)); // R6

endmodule

// File: rtl/divUnit.sv
module divUnit
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] divisor,
  input  logic [DATA_W-1:0] axIn,
  input  logic [DATA_W-1:0] dxIn,
  output logic [DATA_W-1:0] axOut,
  output logic [DATA_W-1:0] dxOut,
  output logic              done,
  output logic              fault
);

  divStrobeT strb;
  logic      tooBig;

  divCtrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wordMode (wordMode),
    .tooBig   (tooBig),
    .strb     (strb),
    .done     (done),
    .fault    (fault)
  );

  divPath #(.DATA_W(DATA_W)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordMode (wordMode),
    .divisor  (divisor),
    .axIn     (axIn),
    .dxIn     (dxIn),
    .tooBig   (tooBig),
    .axOut    (axOut),
    .dxOut    (dxOut)
  );

endmodule

// File: tb/divUnit_tb_top.sv
`timescale 1ns/1ps
module divUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wordMode = 1'b0;
  logic [15:0] divisor = '0;
  logic [15:0] axIn = '0;
  logic [15:0] dxIn = '0;
  logic [15:0] axOut;
  logic [15:0] dxOut;
  logic        done;
  logic        fault;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  divUnit #(.DATA_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .wordMode(wordMode),
    .divisor(divisor), .axIn(axIn), .dxIn(dxIn),
    .axOut(axOut), .dxOut(dxOut), .done(done), .fault(fault)
  );

  // {expected fault, wordMode, divisor, axIn, dxIn}
  localparam int NVEC = 10;
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 16'h0007, 16'h0064, 16'h1234},
    {1'b0, 1'b0, 16'h00FF, 16'hFE01, 16'hA5A5},
    {1'b1, 1'b0, 16'h0010, 16'h1000, 16'h0F0F},
    {1'b1, 1'b0, 16'h0000, 16'h0042, 16'h7777},
    {1'b0, 1'b1, 16'h1234, 16'h0000, 16'h0001},
    {1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFE},
    {1'b1, 1'b1, 16'h0100, 16'h5555, 16'h0100},
    {1'b1, 1'b1, 16'h0000, 16'h0001, 16'h0000},
    {1'b0, 1'b0, 16'hAB03, 16'h0050, 16'h3C3C},
    {1'b0, 1'b1, 16'h0001, 16'hBEEF, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where done is seen
  task automatic runOp(input bit wm, input logic [15:0] dv, input logic [15:0] ax,
                       input logic [15:0] dx, input bit expFault, input string req,
                       input bit checkGap);
    logic [31:0] dvd;
    logic [31:0] dvs;
    logic [31:0] q;
    logic [31:0] r;
    bit          ovf;
    logic [15:0] expAx;
    logic [15:0] expDx;
    int          expLat;
    int          lat;
    dvd = wm ? {dx, ax} : {16'h0, ax};
    dvs = wm ? {16'h0, dv} : {24'h0, dv[7:0]};
    ovf = (dvs == 0);
    q = 0; r = 0;
    if (!ovf) begin
      q = dvd / dvs;
      r = dvd % dvs;
      ovf = (q > (wm ? 32'hFFFF : 32'hFF));
    end
    if (ovf) begin
      expAx = ax; expDx = dx; expLat = 0;
    end else if (wm) begin
      expAx = q[15:0]; expDx = r[15:0]; expLat = 16;
    end else begin
      expAx = {r[7:0], q[7:0]}; expDx = dx; expLat = 8;
    end
    chk(ovf == expFault, req, "bench table fault", longint'(ovf), longint'(expFault));
    wordMode = wm; divisor = dv; axIn = ax; dxIn = dx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == expLat, "R7", "latency", lat, expLat);
    chk(fault == expFault, expFault ? "R5/R6" : req, "fault", fault, expFault);
    chk(axOut == expAx, req, "axOut", axOut, expAx);
    chk(dxOut == expDx, wm ? req : "R4", "dxOut", dxOut, expDx);
    if (checkGap) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", "done after pulse", done, 0);
      chk(fault == 1'b0, "R8", "fault after pulse", fault, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(done == 0, "R11", "done", done, 0);
    chk(fault == 0, "R11", "fault", fault, 0);
    chk(axOut == 0, "R11", "axOut", axOut, 0);
    chk(dxOut == 0, "R11", "dxOut", dxOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R1, R2, R3, R4, R5, R6 by vector
    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], VEC[i][49],
            VEC[i][48] ? "R3" : "R1/R2", 1'b1);
    end

    // R9: start while busy is ignored
    begin
      int lat;
      wordMode = 1'b1; divisor = 16'h0003; axIn = 16'h0030; dxIn = 16'h0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      wordMode = 1'b0; divisor = 16'h0001; axIn = 16'h0009; dxIn = 16'h1111; start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == 16, "R9", "latency with extra start", lat, 16);
      chk(axOut == 16'h0010, "R9", "axOut", axOut, 16'h0010);
      chk(dxOut == 16'h0000, "R9", "dxOut", dxOut, 16'h0000);
      @(negedge clk);
      chk(done == 0, "R9", "no second done", done, 0);
    end

    // R10: start in the done cycle is accepted (good op then good op)
    runOp(1'b0, 16'h0009, 16'h0100, 16'h2222, 1'b0, "R10", 1'b0);
    runOp(1'b1, 16'h0101, 16'h0202, 16'h0000, 1'b0, "R10", 1'b1);
    // R10: good op immediately followed by a faulting op
    runOp(1'b0, 16'h0005, 16'h0019, 16'h3333, 1'b0, "R10", 1'b0);
    runOp(1'b1, 16'h0002, 16'hFFFF, 16'h0002, 1'b1, "R10", 1'b1);
    // R6: byte boundary, AH just below divisor is fine
    runOp(1'b0, 16'h0010, 16'h0FFF, 16'h4444, 1'b0, "R6", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule